// File: doc/BRIEF.md
# Profiled DDS Phase Core

This core is the digital heart of a direct digital synthesizer. A 32-bit phase accumulator advances by a frequency tuning word on every system clock. A 14-bit phase offset, aligned to the top of the phase word, is added after the accumulator. The sum is cut down to 15 bits, and a quarter-wave symmetric amplitude map turns it into a signed 10-bit sample. The converter, the analog loop and the register bus all sit outside the core.

Four profiles each hold a tuning word and an offset. A profile-select input chooses which one drives the datapath. Writes land in shadow copies of the profiles. All four active copies are reloaded together only after an update strobe. The strobe is sampled once per period of a divide-by-8 sync clock, which the core also drives out, and the reload is timed so that the first sample built from the new values leaves the core a fixed 83 clocks after the sampling edge.

Top module: `dds_phase_core`

## Requirements
- R1: While rst_ni is low, amp_o is 0 and sync_clk_o is 0. The accumulator and all active and shadow profiles reset to zero.
- R2: sync_clk_o is the system clock divided by 8. It is low for the first 4 rising edges after reset is released, then high for 4 edges, and the pattern repeats.
- R3: upd_i is sampled only on the rising edge where sync_clk_o goes from high to low (the sync sampling edge). An update is detected when the sample is 1 and the previous sample was 0. A pulse that starts and ends between two sampling edges has no effect.
- R4: A write (wr_en_i high at a rising edge) loads wr_ftw_i and wr_poff_i into the shadow copy of profile wr_prof_i only. The active profiles change only on a commit, and a commit copies all four shadows at once.
- R5: A detected update commits 80 edges after the sampling edge. The first amp_o sample computed from the committed values appears exactly 83 edges after the sampling edge. Any update detected while a commit is pending is ignored.
- R6: On each rising edge the accumulator adds the tuning word of the active profile chosen by prof_sel_i, wrapping modulo 2^32.
- R7: acc_clr_i high at a rising edge sets the accumulator to zero, overriding the add. With the offset at 0 and acc_clr_i held, amp_o settles to 0.
- R8: The phase is p = bits [31:17] of (acc + (offset << 18)) mod 2^32.
- R9: With p[14] as the sign and p[13] as the mirror bit, let q = 8192 - p[12:0] when p[13] = 1, else q = p[12:0]. Then mag = floor(q*(16384-q)*511 / 2^26), and amp_o is mag when p[14] = 0, or -mag (two's complement) when p[14] = 1. Example values: offset 0x1000 gives 511, 0x2000 gives 0, 0x3000 gives 0x201 (-511), 0x0800 gives 383. The code 0x200 never appears.
- R10: The offset used is registered alongside the accumulator, from the profile selected in the same cycle. amp_o after edge k is derived from the accumulator and offset registers as they stood after edge k-2.
- R11: A change on prof_sel_i switches both the tuning word and the offset source at the next rising edge. It reaches amp_o three edges later.

Both the bench and R5 count the latency from the sync sampling edge. A strobe that rises between sampling edges waits for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow profile write enable |
| wr_prof_i | input | 2 | Profile index for the write |
| wr_ftw_i | input | 32 | Tuning word to write |
| wr_poff_i | input | 14 | Phase offset to write |
| prof_sel_i | input | 2 | Active profile select |
| upd_i | input | 1 | Update strobe, sampled on the sync clock |
| acc_clr_i | input | 1 | Synchronous accumulator clear |
| sync_clk_o | output | 1 | System clock divided by 8 |
| amp_o | output | 10 | Signed amplitude sample |

## Verification
The bench targets the exact edge on which a committed offset first reaches the output. A design that counts 82 or 84 edges, or that forgets to line up the offset and tuning-word pipelines, flips the peak sample one edge early or late. It also sends a strobe pulse that falls between sampling edges, and writes that are never committed. A core that samples the strobe every clock, or that exposes shadow writes directly, changes the output where it must not. Directed offsets hit the quadrant boundaries: a core with a wrong mirror or sign bit returns 0 instead of the peak, or +511 where -511 is due. Random traffic also checks wrap-around, clears and profile switches against a cycle-accurate model.

// File: rtl/dds_pkg.sv
package dds_pkg;
  parameter int FTW_W      = 32;
  parameter int POFF_W     = 14;
  parameter int PH_W       = 15;
  parameter int AMP_W      = 10;
  parameter int NPROF      = 4;
  parameter int SYNC_DIV   = 8;
  parameter int UPD_LAT    = 83;
  parameter int PIPE_DEPTH = 3;

  localparam int PROF_W = $clog2(NPROF);

  typedef struct packed {
    logic [FTW_W-1:0]  ftw;
    logic [POFF_W-1:0] poff;
  } prof_t;
endpackage

// File: rtl/dds_sync_ctrl.sv
module dds_sync_ctrl #(
  parameter int DIV  = 8,
  parameter int LAT  = 83,
  parameter int PIPE = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  output logic sync_clk_o,
  output logic det_o,
  output logic commit_o
);
  localparam int DW  = $clog2(DIV);
  localparam int DLY = LAT - PIPE;
  localparam int CW  = $clog2(DLY + 1);

  logic [DW-1:0] div_q;
  logic          upd_s_q;
  logic [CW-1:0] pend_q;
  logic          tick;

  assign tick       = (div_q == DW'(DIV - 1));
  assign sync_clk_o = (div_q >= DW'(DIV / 2));
  assign det_o      = tick & upd_i & ~upd_s_q & (pend_q == '0);
  assign commit_o   = (pend_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      upd_s_q <= 1'b0;
      pend_q  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) upd_s_q <= upd_i;
      if (det_o)              pend_q <= CW'(DLY);
      else if (pend_q != '0)  pend_q <= pend_q - 1'b1;
    end
  end
endmodule

// File: rtl/dds_profile_bank.sv
module dds_profile_bank
  import dds_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [PROF_W-1:0]       wr_sel_i,
  input  prof_t                   wr_data_i,
  input  logic                    commit_i,
  input  logic [PROF_W-1:0]       rd_sel_i,
  output prof_t [NPROF-1:0]       act_o,
  output prof_t                   rd_o
);
  prof_t [NPROF-1:0] shadow_q;

  for (genvar g = 0; g < NPROF; g++) begin : g_prof
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g] <= '0;
        act_o[g]    <= '0;
      end else begin
        if (wr_en_i && wr_sel_i == PROF_W'(g)) shadow_q[g] <= wr_data_i;
        if (commit_i) act_o[g] <= shadow_q[g];
      end
    end
  end

  assign rd_o = act_o[rd_sel_i];
endmodule

// File: rtl/dds_sine_map.sv
module dds_sine_map
  import dds_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  ph_i,
  output logic [AMP_W-1:0] amp_o
);
  localparam int QW   = PH_W - 2;
  localparam int HALF = 2 ** (QW + 1);
  localparam int PEAK = 2 ** (AMP_W - 1) - 1;
  localparam int PW   = 2 * QW + 2 + AMP_W;

  logic [QW:0]      q;
  logic [QW+1:0]    comp;
  logic [PW-1:0]    prod;
  logic [AMP_W-2:0] mag;
  logic [AMP_W-1:0] mag_ext;

  // mirror on odd quadrants, negate on the lower half wave
  assign q       = ph_i[PH_W-2] ? ((QW+1)'(2 ** QW) - {1'b0, ph_i[QW-1:0]})
                                : {1'b0, ph_i[QW-1:0]};
  assign comp    = (QW+2)'(HALF) - {1'b0, q};
  assign prod    = PW'(q) * PW'(comp) * PW'(PEAK);
  assign mag     = (AMP_W-1)'(prod >> (2 * QW));
  assign mag_ext = {1'b0, mag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_o <= '0;
    else         amp_o <= ph_i[PH_W-1] ? (~mag_ext + 1'b1) : mag_ext;
  end
endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PROF_W-1:0] wr_prof_i,
  input  logic [FTW_W-1:0]  wr_ftw_i,
  input  logic [POFF_W-1:0] wr_poff_i,
  input  logic [PROF_W-1:0] prof_sel_i,
  input  logic              upd_i,
  input  logic              acc_clr_i,
  output logic              sync_clk_o,
  output logic [AMP_W-1:0]  amp_o
);
  localparam int OFF_SH = FTW_W - POFF_W;
  localparam int TR_SH  = FTW_W - PH_W;

  logic              upd_det;
  logic              commit;
  prof_t [NPROF-1:0] act_prof;
  prof_t             sel_prof;
  prof_t             wr_data;

  logic [FTW_W-1:0]  acc_q;
  logic [POFF_W-1:0] poff_q;
  logic [FTW_W-1:0]  phase_sum;
  logic [PH_W-1:0]   ph_q;

  dds_sync_ctrl #(
    .DIV (SYNC_DIV),
    .LAT (UPD_LAT),
    .PIPE(PIPE_DEPTH)
  ) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .sync_clk_o(sync_clk_o),
    .det_o     (upd_det),
    .commit_o  (commit)
  );

  assign wr_data = '{ftw: wr_ftw_i, poff: wr_poff_i};

  dds_profile_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_prof_i),
    .wr_data_i(wr_data),
    .commit_i (commit),
    .rd_sel_i (prof_sel_i),
    .act_o    (act_prof),
    .rd_o     (sel_prof)
  );

  // offset registered beside the accumulator so both paths share one latency
  assign phase_sum = acc_q + {poff_q, {OFF_SH{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      poff_q <= '0;
      ph_q   <= '0;
    end else begin
      acc_q  <= acc_clr_i ? '0 : acc_q + sel_prof.ftw;
      poff_q <= sel_prof.poff;
      ph_q   <= PH_W'(phase_sum >> TR_SH);
    end
  end

  dds_sine_map u_sine (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ph_i  (ph_q),
    .amp_o (amp_o)
  );
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk
  import dds_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_clr_i,
  input logic              sync_clk_i,
  input logic              det_i,
  input logic              commit_i,
  input prof_t [NPROF-1:0] act_i,
  input logic [FTW_W-1:0]  acc_i,
  input logic [AMP_W-1:0]  amp_i
);
  localparam int DLY = UPD_LAT - PIPE_DEPTH;
  localparam int CW  = $clog2(DLY + 2);

  logic [CW-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lat_q <= '0;
    else if (det_i)           lat_q <= CW'(1);
    else if (commit_i)        lat_q <= '0;
    else if (lat_q != '0)     lat_q <= lat_q + 1'b1;
  end

  p_sync_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_clk_i != $past(sync_clk_i)) |=> $stable(sync_clk_i));

  p_active_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_i));

  p_commit_lat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> (lat_q == CW'(DLY)));

  p_acc_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr_i |=> (acc_i == '0));

  p_no_neg_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_i != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

bind dds_phase_core dds_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .acc_clr_i (acc_clr_i),
  .sync_clk_i(sync_clk_o),
  .det_i     (upd_det),
  .commit_i  (commit),
  .act_i     (act_prof),
  .acc_i     (acc_q),
  .amp_i     (amp_o)
);

// File: tb/tb_dds_phase_core.sv
module tb_dds_phase_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_prof = '0;
  logic [31:0] wr_ftw = '0;
  logic [13:0] wr_poff = '0;
  logic [1:0]  prof_sel = '0;
  logic        upd = 1'b0;
  logic        acc_clr = 1'b0;
  logic        sync_clk;
  logic [9:0]  amp;

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dds_phase_core dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_prof_i (wr_prof),
    .wr_ftw_i  (wr_ftw),
    .wr_poff_i (wr_poff),
    .prof_sel_i(prof_sel),
    .upd_i     (upd),
    .acc_clr_i (acc_clr),
    .sync_clk_o(sync_clk),
    .amp_o     (amp)
  );

  function automatic logic [9:0] sine_ref(input logic [14:0] p);
    longint q, mag;
    q   = p[13] ? (8192 - longint'(p[12:0])) : longint'(p[12:0]);
    mag = (q * (16384 - q) * 511) >>> 26;
    return p[14] ? 10'(-mag) : 10'(mag);
  endfunction

  // cycle-accurate reference built from the requirements
  int          m_div, m_pend;
  bit          m_upd, m_tick, m_det;
  logic [31:0] m_sh_ftw [4];
  logic [13:0] m_sh_poff[4];
  logic [31:0] m_ac_ftw [4];
  logic [13:0] m_ac_poff[4];
  logic [31:0] m_acc, m_sum;
  logic [13:0] m_poffq;
  logic [14:0] m_ph;
  logic [9:0]  m_amp;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div <= 0; m_pend <= 0; m_upd <= 0;
      for (int i = 0; i < 4; i++) begin
        m_sh_ftw[i] <= '0; m_sh_poff[i] <= '0; m_ac_ftw[i] <= '0; m_ac_poff[i] <= '0;
      end
      m_acc <= '0; m_poffq <= '0; m_ph <= '0; m_amp <= '0;
    end else begin
      m_tick = (m_div == 7);
      m_det  = m_tick && upd && !m_upd && (m_pend == 0);
      m_div  <= m_tick ? 0 : m_div + 1;
      if (m_tick) m_upd <= upd;
      m_pend <= m_det ? 80 : (m_pend != 0 ? m_pend - 1 : 0);
      if (m_pend == 1)
        for (int i = 0; i < 4; i++) begin
          m_ac_ftw[i] <= m_sh_ftw[i]; m_ac_poff[i] <= m_sh_poff[i];
        end
      if (wr_en) begin
        m_sh_ftw[wr_prof] <= wr_ftw; m_sh_poff[wr_prof] <= wr_poff;
      end
      m_acc   <= acc_clr ? 32'd0 : m_acc + m_ac_ftw[prof_sel];
      m_poffq <= m_ac_poff[prof_sel];
      m_sum    = m_acc + {m_poffq, 18'd0};
      m_ph    <= m_sum[31:17];
      m_amp   <= sine_ref(m_ph);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && run_cmp) begin
      check(amp == m_amp, "R6/R8/R10 amp vs model", amp, m_amp);
      check(sync_clk == (m_div >= 4), "R2 sync clock", sync_clk, m_div >= 4);
    end
  end

  task automatic write_prof(input logic [1:0] p, input logic [31:0] f, input logic [13:0] o);
    wr_en = 1'b1; wr_prof = p; wr_ftw = f; wr_poff = o;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit_all();
    upd = 1'b1;
    repeat (100) @(negedge clk);
    upd = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic wait_sync_fall();
    bit prev;
    prev = sync_clk;
    @(negedge clk);
    while (!(prev && !sync_clk)) begin
      prev = sync_clk;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(amp == 10'd0, "R1 reset amp", amp, 0);
    check(sync_clk == 1'b0, "R1 reset sync", sync_clk, 0);
    rst_ni = 1'b1;
    run_cmp = 1'b1;

    // R4: uncommitted write must not reach the output
    write_prof(2'd0, 32'd0, 14'h1000);
    repeat (200) @(negedge clk);
    check(amp == 10'd0, "R4 shadow isolated", amp, 0);

    // R3: pulse between sampling edges is ignored
    wait_sync_fall();
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    repeat (100) @(negedge clk);
    check(amp == 10'd0, "R3 short pulse ignored", amp, 0);

    // R5: exact update-to-output latency
    upd = 1'b1;
    wait_sync_fall();
    repeat (82) @(negedge clk);
    check(amp == 10'd0, "R5 edge 82 old value", amp, 0);
    @(negedge clk);
    check(amp == 10'd511, "R5 edge 83 new value", amp, 511);
    upd = 1'b0;
    repeat (16) @(negedge clk);

    // R9: quadrant points
    write_prof(2'd0, 32'd0, 14'h2000); commit_all();
    check(amp == 10'd0, "R9 half turn", amp, 0);
    write_prof(2'd0, 32'd0, 14'h3000); commit_all();
    check(amp == 10'h201, "R9 three quarter", amp, 10'h201);
    write_prof(2'd0, 32'd0, 14'h0800); commit_all();
    check(amp == 10'd383, "R9 eighth turn", amp, 383);

    // R11: profile select
    write_prof(2'd1, 32'd0, 14'h3000);
    write_prof(2'd2, 32'd0, 14'h1000);
    commit_all();
    prof_sel = 2'd1;
    repeat (4) @(negedge clk);
    check(amp == 10'h201, "R11 select profile 1", amp, 10'h201);
    prof_sel = 2'd2;
    repeat (4) @(negedge clk);
    check(amp == 10'd511, "R11 select profile 2", amp, 511);

    // R6 wrap and R7 clear
    write_prof(2'd3, 32'hFFFF_FFFF, 14'h0000);
    commit_all();
    prof_sel = 2'd3;
    repeat (40) @(negedge clk);
    acc_clr = 1'b1;
    repeat (5) @(negedge clk);
    check(amp == 10'd0, "R7 clear held", amp, 0);
    acc_clr = 1'b0;
    repeat (20) @(negedge clk);

    // constrained random traffic against the model
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 20000; c++) begin
      wr_en   = ($urandom_range(3) == 0);
      wr_prof = 2'($urandom_range(3));
      wr_ftw  = ($urandom_range(7) == 0) ? 32'hFFFF_FFF0 + 32'($urandom_range(15)) : $urandom;
      wr_poff = 14'($urandom);
      if ($urandom_range(15) == 0) prof_sel = 2'($urandom_range(3));
      if ($urandom_range(31) == 0) upd = ~upd;
      acc_clr = ($urandom_range(63) == 0);
      @(negedge clk);
    end
    wr_en = 1'b0; acc_clr = 1'b0; upd = 1'b0;
    repeat (10) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule